// File: doc/BRIEF.md
# Sequencer Tempo Tick Generator

This block produces the base timing pulses of a step sequencer at 96 ticks per quarter note. A free-running prescaler divides the system clock into a one-microsecond count enable. A 16-bit tempo down-counter runs from that enable, and each time it expires it adds one tick to an 8-bit tick counter. The host computes the tempo interval and writes it as a reload value. A rising edge on an external sync input also adds one tick. When both sources fire in the same cycle, the counter advances by two, so no tick is dropped.

A subdivider counts ticks down from 96 and raises a one-cycle beat strobe at each quarter-note boundary. A beat-in-bar counter then advances a four-digit BCD measure number once every `BEATS_PER_BAR` beats. The transport input gates all counting. While stopped, the tick count and the measure are held, and the subdivider and the beat-in-bar position restart. The reset is asynchronous and active-low, and the block releases it internally in step with the clock.

Top module: `seq_tick_gen`

## Requirements
- R1: After reset, `tick_count` is 0, `beat_pulse` is 0, `measure_bcd` is 16'h0001, and the tempo reload value is `DEFAULT_RELOAD`.
- R2: While transport is running, the tempo timer adds one tick every (reload+1)×`CLK_DIV` clock cycles.
- R3: While running, a 0-to-1 transition of `ext_sync`, detected between two consecutive clock edges, adds one tick. A high level held on `ext_sync` adds nothing further.
- R4: A timer expiry and an external edge in the same cycle add two ticks. The tick count never advances by more than two in one cycle.
- R5: A pulse on `tempo_wr` stores `tempo_val`. The stored value is used from the next reload onward, so the interval already in progress keeps its old length.
- R6: Transport is encoded as 0 = stopped, 1 = playing, 2 = recording, and 3 is treated as stopped. When transport is not 1 or 2, `tick_count` and `measure_bcd` stay unchanged and both tick sources are ignored.
- R7: After transport starts, `beat_pulse` is high for exactly one cycle, in the cycle the 96th tick appears on `tick_count`, and then again after every further 96 ticks.
- R8: The measure advances by one on every `BEATS_PER_BAR`-th beat while playing (1) or recording (2). Beat position restarts when transport stops.
- R9: `measure_bcd` holds four BCD digits, with the least significant digit in bits [3:0]. A digit at 9 wraps to 0 and carries into the next digit (0009→0010, 0099→0100).
- R10: The tick count is 8 bits wide and wraps from 255 to 0.
- R11: Every BCD digit of `measure_bcd` is always 9 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tempo_wr | input | 1 | One-cycle strobe that stores `tempo_val` as the reload value |
| tempo_val | input | 16 | Tempo reload value supplied by the host |
| ext_sync | input | 1 | External sync clock, synchronous to `clk`; each rising edge is one tick |
| transport | input | 2 | 0 stopped, 1 playing, 2 recording, 3 treated as stopped |
| tick_count | output | 8 | Running tick count |
| beat_pulse | output | 1 | One-cycle strobe on each quarter-note boundary |
| measure_bcd | output | 16 | Current measure as four BCD digits |

## Verification
The assertions assume that `ext_sync` is already synchronous to `clk`. They also assume that `transport` only ever carries one of the four listed codes, so a rising edge is just the value seen at one clock edge compared with the value at the edge before. The stimulus changes every input on the falling clock edge. It drives `ext_sync` as one-cycle-high, one-cycle-low pulses, so each pulse produces exactly one detected edge. To test coincident ticks, it raises `ext_sync` on the exact edge where the timer expiry falls, computed from the known reload period. To keep counted ticks from being mixed with stray timer ticks, the long counting runs load the largest reload value first.

// File: rtl/seq_tick_pkg.sv
package seq_tick_pkg;

  typedef enum logic [1:0] {
    XPORT_STOP = 2'd0,
    XPORT_PLAY = 2'd1,
    XPORT_REC  = 2'd2,
    XPORT_RSVD = 2'd3
  } xport_e;

  function automatic logic xport_running(input logic [1:0] state);
    return (state == XPORT_PLAY) || (state == XPORT_REC);
  endfunction

endpackage

// File: rtl/seq_tick_prescale.sv
module seq_tick_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  assign stb_o = (cnt_q == W'(DIV - 1));

  always_comb begin
    if (stb_o) cnt_d = '0;
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seq_tick_tempo.sv
module seq_tick_tempo #(
  parameter int            RW      = 16,
  parameter logic [RW-1:0] DEFAULT = RW'(5207)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          run_i,
  input  logic          wr_i,
  input  logic [RW-1:0] wr_data_i,
  output logic          expire_o
);
  logic [RW-1:0] reload_q, reload_d;
  logic [RW-1:0] cnt_q, cnt_d;

  assign expire_o = run_i && stb_i && (cnt_q == '0);

  always_comb begin
    reload_d = wr_i ? wr_data_i : reload_q;
    if (!run_i)          cnt_d = reload_q;
    else if (!stb_i)     cnt_d = cnt_q;
    else if (cnt_q == '0) cnt_d = reload_q;
    else                 cnt_d = cnt_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= DEFAULT;
      cnt_q    <= DEFAULT;
    end else begin
      if (wr_i) reload_q <= reload_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/seq_tick_beat.sv
module seq_tick_beat #(
  parameter int PPQN = 96,
  parameter int BPB  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [1:0] inc_i,
  output logic       beat_o,
  output logic       bar_step_o
);
  localparam int SW = $clog2(PPQN + 3);
  localparam int BW = (BPB > 1) ? $clog2(BPB) : 1;

  logic [SW-1:0] sub_q, sub_d, inc_ext;
  logic [BW-1:0] idx_q, idx_d;
  logic          hit, last_beat, beat_q;

  assign inc_ext    = SW'(inc_i);
  assign hit        = run_i && (inc_ext >= sub_q);
  assign last_beat  = (idx_q == BW'(BPB - 1));
  assign bar_step_o = hit && last_beat;
  assign beat_o     = beat_q;

  always_comb begin
    if (!run_i)   sub_d = SW'(PPQN);
    else if (hit) sub_d = sub_q + SW'(PPQN) - inc_ext;
    else          sub_d = sub_q - inc_ext;

    if (!run_i)   idx_d = '0;
    else if (hit) idx_d = last_beat ? '0 : idx_q + BW'(1);
    else          idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= SW'(PPQN);
      idx_q  <= '0;
      beat_q <= 1'b0;
    end else begin
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      beat_q <= hit;
    end
  end
endmodule

// File: rtl/seq_tick_bcd.sv
module seq_tick_bcd #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  output logic [4*DIGITS-1:0] bcd_o
);
  logic [DIGITS-1:0] carry;

  assign carry[0] = step_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig_q, dig_d;

    always_comb begin
      dig_d = (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end

    if (g < DIGITS - 1) begin : g_carry
      assign carry[g+1] = carry[g] && (dig_q == 4'd9);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dig_q <= (g == 0) ? 4'd1 : 4'd0;
      else if (carry[g]) dig_q <= dig_d;
    end

    assign bcd_o[4*g +: 4] = dig_q;
  end
endmodule

// File: rtl/seq_tick_gen.sv
module seq_tick_gen
  import seq_tick_pkg::*;
#(
  parameter int                  CLK_DIV        = 12,
  parameter int                  RELOAD_W       = 16,
  parameter logic [RELOAD_W-1:0] DEFAULT_RELOAD = RELOAD_W'(5207),
  parameter int                  PPQN           = 96,
  parameter int                  BEATS_PER_BAR  = 4,
  parameter int                  TICK_W         = 8,
  parameter int                  MEAS_DIGITS    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tempo_wr,
  input  logic [RELOAD_W-1:0]      tempo_val,
  input  logic                     ext_sync,
  input  logic [1:0]               transport,
  output logic [TICK_W-1:0]        tick_count,
  output logic                     beat_pulse,
  output logic [4*MEAS_DIGITS-1:0] measure_bcd
);
  logic              rst_meta_q, rst_sync_n;
  logic              us_stb, expire, run, sync_q, ext_edge, bar_step;
  logic [1:0]        inc;
  logic [TICK_W-1:0] tick_q, tick_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign run      = xport_running(transport);
  assign ext_edge = ext_sync && !sync_q;

  always_comb begin
    inc    = {1'b0, expire} + {1'b0, ext_edge && run};
    tick_d = tick_q + TICK_W'(inc);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sync_q <= 1'b0;
      tick_q <= '0;
    end else begin
      sync_q <= ext_sync;
      if (run) tick_q <= tick_d;
    end
  end

  assign tick_count = tick_q;

  seq_tick_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .stb_o(us_stb)
  );

  seq_tick_tempo #(.RW(RELOAD_W), .DEFAULT(DEFAULT_RELOAD)) u_tempo (
    .clk(clk), .rst_n(rst_sync_n), .stb_i(us_stb), .run_i(run),
    .wr_i(tempo_wr), .wr_data_i(tempo_val), .expire_o(expire)
  );

  seq_tick_beat #(.PPQN(PPQN), .BPB(BEATS_PER_BAR)) u_beat (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run), .inc_i(inc),
    .beat_o(beat_pulse), .bar_step_o(bar_step)
  );

  seq_tick_bcd #(.DIGITS(MEAS_DIGITS)) u_meas (
    .clk(clk), .rst_n(rst_sync_n), .step_i(bar_step), .bcd_o(measure_bcd)
  );
endmodule

// File: rtl/seq_tick_gen_chk.sv
module seq_tick_gen_chk #(
  parameter int TICK_W      = 8,
  parameter int MEAS_DIGITS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ext_sync,
  input logic [1:0]               transport,
  input logic [TICK_W-1:0]        tick_count,
  input logic                     beat_pulse,
  input logic [4*MEAS_DIGITS-1:0] measure_bcd
);
  logic running;
  assign running = (transport == 2'd1) || (transport == 2'd2);

  function automatic logic digits_ok(input logic [4*MEAS_DIGITS-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < MEAS_DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R6: no tick movement while stopped or reserved
  a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(tick_count));

  // R3: a sampled rising edge while running moves the tick count
  a_r3_edge_counts: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_sync) && running) |=> (tick_count != $past(tick_count)));

  // R4: never more than two ticks per cycle
  a_r4_step_max_two: assert property (@(posedge clk) disable iff (!rst_n)
    TICK_W'(tick_count - $past(tick_count)) <= TICK_W'(2));

  // R7: beat strobe is a single cycle and coincides with a tick
  a_r7_beat_single: assert property (@(posedge clk) disable iff (!rst_n)
    beat_pulse |=> !beat_pulse);
  a_r7_beat_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    beat_pulse |-> (tick_count != $past(tick_count)));

  // R8: measure only moves together with a beat
  a_r8_measure_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (measure_bcd != $past(measure_bcd)) |-> beat_pulse);

  // R11: all BCD digits legal
  a_r11_digits_valid: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(measure_bcd));
endmodule

bind seq_tick_gen seq_tick_gen_chk #(.TICK_W(TICK_W), .MEAS_DIGITS(MEAS_DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_sync(ext_sync), .transport(transport),
  .tick_count(tick_count), .beat_pulse(beat_pulse), .measure_bcd(measure_bcd)
);

// File: tb/seq_tick_gen_test.sv
module seq_tick_gen_test;
  localparam int DIV = 12;
  localparam int DEF = 7;
  localparam int PPQN = 96;
  localparam int BPB = 2;
  localparam int BAR_TICKS = PPQN * BPB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tempo_wr = 1'b0;
  logic [15:0] tempo_val = '0;
  logic        ext_sync = 1'b0;
  logic [1:0]  transport = 2'd0;
  logic [7:0]  tick_count;
  logic        beat_pulse;
  logic [15:0] measure_bcd;

  int n_checks = 0;
  int n_fail = 0;
  int run_ticks = 0;

  always #4 clk = ~clk;

  seq_tick_gen #(
    .CLK_DIV(DIV), .DEFAULT_RELOAD(16'(DEF)), .PPQN(PPQN), .BEATS_PER_BAR(BPB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tempo_wr(tempo_wr), .tempo_val(tempo_val),
    .ext_sync(ext_sync), .transport(transport), .tick_count(tick_count),
    .beat_pulse(beat_pulse), .measure_bcd(measure_bcd)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_ext();
    @(negedge clk) ext_sync = 1'b1;
    @(negedge clk) ext_sync = 1'b0;
    run_ticks++;
  endtask

  task automatic write_reload(input logic [15:0] v);
    tempo_val = v;
    tempo_wr  = 1'b1;
    @(negedge clk) tempo_wr = 1'b0;
  endtask

  task automatic wait_change(output int cyc, output int delta);
    logic [7:0] prev = tick_count;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (tick_count == prev && cyc < 5000);
    delta = int'(8'(tick_count - prev));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "tick after reset", tick_count, 0);
    check("R1", "beat after reset", beat_pulse, 0);
    check("R1", "measure after reset", measure_bcd, 16'h0001);
  endtask

  task automatic t_default_period();
    int c, d;
    transport = 2'd1;
    wait_change(c, d);
    wait_change(c, d);
    check("R1", "default reload period", c, (DEF + 1) * DIV);
    check("R2", "timer tick step", d, 1);
  endtask

  task automatic t_reload_write();
    int c, d;
    write_reload(16'd3);
    wait_change(c, d);
    check("R5", "interval in progress keeps old length", c + 1, (DEF + 1) * DIV);
    wait_change(c, d);
    check("R5", "new reload used after next reload", c, 4 * DIV);
    wait_change(c, d);
    check("R2", "period with reload 3", c, 4 * DIV);
  endtask

  task automatic t_simultaneous();
    int c, d;
    logic [7:0] prev;
    wait_change(c, d);
    prev = tick_count;
    repeat (4 * DIV - 1) @(negedge clk);
    ext_sync = 1'b1;
    @(negedge clk);
    check("R4", "timer and edge together", 8'(tick_count - prev), 2);
    ext_sync = 1'b0;
    write_reload(16'hFFFF);
    wait_change(c, d);
  endtask

  task automatic t_ext_edge();
    logic [7:0] prev = tick_count;
    pulse_ext();
    check("R3", "one edge one tick", 8'(tick_count - prev), 1);
    @(negedge clk) ext_sync = 1'b1;
    repeat (6) @(negedge clk);
    check("R3", "held level counts once", 8'(tick_count - prev), 2);
    ext_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stopped();
    logic [7:0]  prev;
    logic [15:0] meas;
    @(negedge clk) transport = 2'd0;
    prev = tick_count;
    meas = measure_bcd;
    repeat (5) pulse_ext();
    write_reload(16'd0);
    repeat (100) @(negedge clk);
    check("R6", "stopped ignores edges and timer", tick_count, prev);
    check("R6", "stopped holds measure", measure_bcd, meas);
    transport = 2'd3;
    repeat (3) pulse_ext();
    repeat (50) @(negedge clk);
    check("R6", "code 3 treated as stopped", tick_count, prev);
    write_reload(16'hFFFF);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_beat();
    logic seen = 1'b0;
    transport = 2'd2;
    run_ticks = 0;
    check("R8", "measure before recording run", measure_bcd, 16'h0001);
    repeat (PPQN - 1) begin
      pulse_ext();
      if (beat_pulse) seen = 1'b1;
    end
    check("R7", "no beat before 96 ticks", seen, 0);
    pulse_ext();
    check("R7", "beat on 96th tick", beat_pulse, 1);
    @(negedge clk);
    check("R7", "beat lasts one cycle", beat_pulse, 0);
    check("R8", "no measure step after first beat", measure_bcd, 16'h0001);
    repeat (PPQN) pulse_ext();
    check("R8", "measure steps after bar of beats", measure_bcd, 16'h0002);
  endtask

  task automatic t_wrap();
    while (tick_count != 8'd255) pulse_ext();
    check("R10", "tick reaches 255", tick_count, 255);
    pulse_ext();
    check("R10", "tick wraps to 0", tick_count, 0);
  endtask

  task automatic t_bcd();
    while (run_ticks < 9 * BAR_TICKS - 1) pulse_ext();
    check("R9", "measure before first carry", measure_bcd, 16'h0009);
    pulse_ext();
    check("R9", "units carry into tens", measure_bcd, 16'h0010);
    while (run_ticks < 99 * BAR_TICKS - 1) pulse_ext();
    check("R9", "measure before double carry", measure_bcd, 16'h0099);
    pulse_ext();
    check("R9", "carry ripples into hundreds", measure_bcd, 16'h0100);
  endtask

  initial begin
    t_reset();
    t_default_period();
    t_reload_write();
    t_simultaneous();
    t_ext_edge();
    t_stopped();
    t_beat();
    t_wrap();
    t_bcd();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule